// File: doc/BRIEF.md
# LED Brightness Channel with Ramped Duty

This block drives one LED channel by pulse-width modulation. An 8-bit target duty picks one of 256 brightness steps, where 0 is dark and 255 is the brightest. A free-running 8-bit counter is compared against the live duty to form the drive pin.

The live duty normally follows the target at once. Two optional ramp enables change that. One covers rising changes and one covers falling changes. With an enable set, the live duty moves toward the target one step at a time. Each direction has its own 3-bit speed code. Time is counted in ticks from an internal prescaler. Each step waits `STEP_BASE << code` ticks, so every code doubles the duration of the one below it.

A global enable and a channel enable both gate the channel. While either is low, the channel is dark and the drive-strength code reads as off. A 2-bit drive-strength code (off, low, mid, full) passes through while the channel is enabled.

Top module: `led_fade_channel`

## Requirements
- R1: After reset, `pwm_out` is 0, `lvl_out` is 00 and `duty_live` is 0.
- R2: While `glb_en` or `ch_en` is 0, from the next clock edge `pwm_out` is 0 and `duty_live` is 0, and `lvl_out` reads 00 at once.
- R3: With the live duty held at D, `pwm_out` is high for exactly D cycles out of every 256 consecutive cycles. D=0 gives no high cycle and D=255 gives 255 high cycles.
- R4: With both ramp enables at 0, `duty_live` equals the new `duty_tgt` one clock after the target changes.
- R5: With `fade_up_en`=1 and a target above the live duty, `duty_live` rises by exactly 1 per step and never passes the target.
- R6: Successive ramp steps are spaced exactly `TICK_DIV * (STEP_BASE << code)` clock cycles apart. The code is `up_speed` when rising and `dn_speed` when falling.
- R7: With `fade_dn_en`=1 and a target below the live duty, `duty_live` falls by exactly 1 per step and never goes below the target.
- R8: A target change during a ramp turns the ramp around from the present live value. There is no jump and no restart from 0.
- R9: While the channel is enabled, `lvl_out` equals `lvl_code`. The encoding is 00=off, 01=low, 10=mid, 11=full.
- R10: Each ramp enable applies only to its own direction. With `fade_up_en`=1 and `fade_dn_en`=0, a falling change jumps. With the enables the other way round, a rising change jumps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glb_en | input | 1 | Global enable for the LED function |
| ch_en | input | 1 | Channel enable |
| duty_tgt | input | 8 | Target duty, 0 to 255 |
| fade_up_en | input | 1 | Ramp rising changes |
| fade_dn_en | input | 1 | Ramp falling changes |
| up_speed | input | 3 | Rising step-interval code |
| dn_speed | input | 3 | Falling step-interval code |
| lvl_code | input | 2 | Requested drive-strength code |
| pwm_out | output | 1 | Registered PWM drive |
| lvl_out | output | 2 | Drive-strength code, 00 when disabled |
| duty_live | output | 8 | Present live duty |

## Verification
The hardest case to reach from the ports is a reversal in the middle of a ramp. It needs a ramp already under way at a known speed, then a new target on the far side of the live value. The stimulus starts a slow-enough rise, lets it run for a fixed number of cycles, and reads the live value at a negative edge. It then drives a lower target at that same edge. The next change must be exactly one below the value just read. Step spacing is measured between observed changes, and the first change of each ramp is skipped because the prescaler phase is free-running. This makes each interval check exact without any knowledge of the internals.

// File: rtl/led_fade_pkg.sv
package led_fade_pkg;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MID  = 2'b10,
    LVL_FULL = 2'b11
  } lvl_e;

  // ticks between two ramp steps for a speed code
  function automatic int unsigned step_ticks(input int unsigned base, input logic [2:0] code);
    return base << code;
  endfunction

  // PWM on-condition for a counter value against a duty
  function automatic logic pwm_on(input logic [7:0] cnt, input logic [7:0] duty);
    return cnt < duty;
  endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tcnt <= '0;
    else if (!en)          tcnt <= '0;
    else if (tcnt == LAST) tcnt <= '0;
    else                   tcnt <= tcnt + 1'b1;
  end

  assign tick = en && (tcnt == LAST);
endmodule

// File: rtl/led_fade_ramp.sv
module led_fade_ramp
  import led_fade_pkg::*;
#(
  parameter int STEP_BASE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic [7:0] target,
  input  logic       up_en,
  input  logic       dn_en,
  input  logic [2:0] up_code,
  input  logic [2:0] dn_code,
  output logic [7:0] live
);
  localparam int SCNT_W = $clog2(STEP_BASE * 128) + 1;

  logic [SCNT_W-1:0] scnt;
  logic [SCNT_W-1:0] lim_up, lim_dn, lim;
  logic rising, falling, ramping, step;

  assign lim_up  = SCNT_W'(step_ticks(STEP_BASE, up_code) - 1);
  assign lim_dn  = SCNT_W'(step_ticks(STEP_BASE, dn_code) - 1);
  assign rising  = live < target;
  assign falling = live > target;
  assign ramping = (rising && up_en) || (falling && dn_en);
  assign lim     = rising ? lim_up : lim_dn;
  assign step    = en && ramping && tick && (scnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      scnt <= '0;
    end else if (!en) begin
      live <= '0;
      scnt <= '0;
    end else if ((rising && !up_en) || (falling && !dn_en)) begin
      live <= target;
      scnt <= '0;
    end else if (ramping) begin
      if (step) begin
        scnt <= '0;
        live <= rising ? live + 8'd1 : live - 8'd1;
      end else if (tick) begin
        scnt <= scnt + 1'b1;
      end
    end else begin
      scnt <= '0;
    end
  end

  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up_en && live < target) |=>
      (live == $past(live) || live == $past(live) + 8'd1 || live == 8'd0));

  assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && live < target) |=> (live <= $past(target)));

  assert_no_undershoot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && live > target) |=> (live >= $past(target) || live == 8'd0));
endmodule

// File: rtl/led_pwm_gen.sv
module led_pwm_gen
  import led_fade_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] duty,
  output logic       pwm_q
);
  logic [7:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt   <= en ? cnt + 8'd1 : 8'd0;
      pwm_q <= en && pwm_on(cnt, duty);
    end
  end

  assert_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == 8'd0) |=> !pwm_q);
endmodule

// File: rtl/led_fade_channel.sv
module led_fade_channel
  import led_fade_pkg::*;
#(
  parameter int TICK_DIV  = 4,
  parameter int STEP_BASE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       glb_en,
  input  logic       ch_en,
  input  logic [7:0] duty_tgt,
  input  logic       fade_up_en,
  input  logic       fade_dn_en,
  input  logic [2:0] up_speed,
  input  logic [2:0] dn_speed,
  input  logic [1:0] lvl_code,
  output logic       pwm_out,
  output logic [1:0] lvl_out,
  output logic [7:0] duty_live
);
  logic chan_on;
  logic tick;

  assign chan_on = glb_en && ch_en;
  assign lvl_out = chan_on ? lvl_code : LVL_OFF;

  led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(chan_on), .tick(tick)
  );

  led_fade_ramp #(.STEP_BASE(STEP_BASE)) u_ramp (
    .clk(clk), .rst_n(rst_n), .en(chan_on), .tick(tick),
    .target(duty_tgt), .up_en(fade_up_en), .dn_en(fade_dn_en),
    .up_code(up_speed), .dn_code(dn_speed), .live(duty_live)
  );

  led_pwm_gen u_pwm (
    .clk(clk), .rst_n(rst_n), .en(chan_on), .duty(duty_live), .pwm_q(pwm_out)
  );

  assert_off_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_on |=> (!pwm_out && duty_live == 8'd0));
endmodule

// File: tb/led_fade_channel_bench.sv
module led_fade_channel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0, ch_en = 1'b0;
  logic [7:0] duty_tgt = '0;
  logic fade_up_en = 1'b0, fade_dn_en = 1'b0;
  logic [2:0] up_speed = '0, dn_speed = '0;
  logic [1:0] lvl_code = '0;
  logic pwm_out;
  logic [1:0] lvl_out;
  logic [7:0] duty_live;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  led_fade_channel u_led_fade_channel (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_en(ch_en),
    .duty_tgt(duty_tgt), .fade_up_en(fade_up_en), .fade_dn_en(fade_dn_en),
    .up_speed(up_speed), .dn_speed(dn_speed), .lvl_code(lvl_code),
    .pwm_out(pwm_out), .lvl_out(lvl_out), .duty_live(duty_live)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_out) n++;
    end
  endtask

  task automatic watch_ramp(input int steps, input int spacing, input bit up, input string req);
    logic [7:0] prev;
    int cyc;
    for (int k = 0; k < steps; k++) begin
      prev = duty_live;
      cyc = 0;
      while (duty_live == prev && cyc < 3000) begin
        @(negedge clk);
        cyc++;
      end
      if (up) check(duty_live == 8'(prev + 8'd1), req, duty_live, prev + 1);
      else    check(duty_live == 8'(prev - 8'd1), req, duty_live, prev - 1);
      if (k > 0) check(cyc == spacing, "R6", cyc, spacing);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(pwm_out == 1'b0, "R1", pwm_out, 0);
    check(lvl_out == 2'b00, "R1", lvl_out, 0);
    check(duty_live == 8'd0, "R1", duty_live, 0);
    rst_n = 1'b1;
    glb_en = 1'b1; ch_en = 1'b1;
  endtask

  task automatic t_jump_and_pwm;
    int n;
    duty_tgt = 8'd100;
    @(negedge clk);
    check(duty_live == 8'd100, "R4", duty_live, 100);
    duty_tgt = 8'd20;
    @(negedge clk);
    check(duty_live == 8'd20, "R4", duty_live, 20);
    duty_tgt = 8'd0;
    repeat (3) @(negedge clk);
    count_high(n); check(n == 0, "R3", n, 0);
    duty_tgt = 8'd255;
    repeat (3) @(negedge clk);
    count_high(n); check(n == 255, "R3", n, 255);
    duty_tgt = 8'd77;
    repeat (3) @(negedge clk);
    count_high(n); check(n == 77, "R3", n, 77);
    duty_tgt = 8'd0;
    @(negedge clk);
  endtask

  task automatic t_fade;
    fade_up_en = 1'b1; up_speed = 3'd0; dn_speed = 3'd6;
    duty_tgt = 8'd10;
    watch_ramp(10, 4, 1'b1, "R5");
    repeat (40) @(negedge clk);
    check(duty_live == 8'd10, "R5", duty_live, 10);
    up_speed = 3'd2;
    duty_tgt = 8'd14;
    watch_ramp(4, 16, 1'b1, "R5");
    fade_dn_en = 1'b1; dn_speed = 3'd1; up_speed = 3'd5;
    duty_tgt = 8'd5;
    watch_ramp(9, 8, 1'b0, "R7");
    repeat (40) @(negedge clk);
    check(duty_live == 8'd5, "R7", duty_live, 5);
  endtask

  task automatic t_mixed;
    fade_up_en = 1'b1; fade_dn_en = 1'b0;
    duty_tgt = 8'd2;
    @(negedge clk);
    check(duty_live == 8'd2, "R10", duty_live, 2);
    fade_up_en = 1'b0; fade_dn_en = 1'b1;
    duty_tgt = 8'd6;
    @(negedge clk);
    check(duty_live == 8'd6, "R10", duty_live, 6);
  endtask

  task automatic t_redirect;
    logic [7:0] v;
    fade_up_en = 1'b1; fade_dn_en = 1'b1;
    up_speed = 3'd0; dn_speed = 3'd0;
    duty_tgt = 8'd200;
    repeat (41) @(negedge clk);
    v = duty_live;
    check(v > 8'd6 && v < 8'd200, "R8", v, 7);
    duty_tgt = 8'd0;
    watch_ramp(3, 4, 1'b0, "R8");
    check(duty_live == 8'(v - 8'd3), "R8", duty_live, v - 3);
  endtask

  task automatic t_enable;
    int n;
    lvl_code = 2'b10; #1;
    check(lvl_out == 2'b10, "R9", lvl_out, 2);
    lvl_code = 2'b11; #1;
    check(lvl_out == 2'b11, "R9", lvl_out, 3);
    fade_up_en = 1'b0; fade_dn_en = 1'b0;
    duty_tgt = 8'd255;
    @(negedge clk);
    ch_en = 1'b0; #1;
    check(lvl_out == 2'b00, "R2", lvl_out, 0);
    @(negedge clk);
    check(duty_live == 8'd0, "R2", duty_live, 0);
    count_high(n); check(n == 0, "R2", n, 0);
    ch_en = 1'b1; glb_en = 1'b0; lvl_code = 2'b01;
    @(negedge clk);
    check(duty_live == 8'd0 && pwm_out == 1'b0, "R2", duty_live, 0);
    check(lvl_out == 2'b00, "R2", lvl_out, 0);
    glb_en = 1'b1; #1;
    check(lvl_out == 2'b01, "R9", lvl_out, 1);
    @(negedge clk);
    check(duty_live == 8'd255, "R4", duty_live, 255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_jump_and_pwm();
    t_fade();
    t_mixed();
    t_redirect();
    t_enable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule